// File: doc/BRIEF.md
# Three-Format Instruction Decoder

This block sits between the fetch and execute stages of a small in-order pipeline. It takes one 32-bit instruction word per cycle together with its fetch address. It produces a registered micro-operation for the execute stage. The micro-operation holds an action, an ALU operation, a branch condition, two source operand descriptors and one destination descriptor. Each descriptor is a mode plus a 24-bit value.

The top three bits of the word select the layout of the remaining fields:

- **Control / long immediate.** Jumps, calls, return, stack-pointer load and no-op.
- **Register-register.** ALU, memory, stack and halt operations.
- **Half-word immediate load.**

When execute reports busy, the decoder freezes its output and tells fetch that decode has not taken the word. A jump, call or return raises a fetch-hold flag alongside its micro-operation, so fetch stops until the target is known. Any encoding outside the defined set is dropped and sets a sticky error flag.

Top module: `instr_decoder`

## Requirements
- R1: After reset, `uop_valid`, `fetch_hold` and `err` are 0, and every micro-operation field and `uop_addr` is 0.
- R2: Bits 31:29 select the format (0 control, 1 register-register, 2 half-word load). A valid word whose bits 31:29 are 3 to 7 produces `uop_valid`=0 and sets `err` on the next edge.
- R3: In format 0, opcode bits 28:24 equal to 0x01–0x07 decode as a jump (action 3) and 0x11–0x17 as a call (action 4). The condition is the opcode's low three bits minus one (0 always, 1 zero, 2 not zero, 3 carry, 4 not carry, 5 sign, 6 not sign). The destination is mode 1 (immediate) with value bits 23:0.
- R4: In format 0, the remaining opcodes decode as follows:
  - 0x00 is a no-op: action 0 with all modes 0.
  - 0x0F is a move (action 2) with source 1 immediate bits 23:0 and destination mode 2 (register) value 0xFF, which selects the stack pointer.
  - 0x10 is a return (action 5).
  - Any other format-0 opcode is illegal.
- R5: `fetch_hold` is 1 in exactly the cycles where a valid jump, call or return micro-operation is presented.
- R6: In format 1, the opcode is bits 28:16, and both sources are mode 2 with values bits 15:8 and bits 7:0. The action is:
  - 5 → halt (6)
  - 6 → push (7)
  - 7 → pop (8)
  - 8, 9 and 0x12 → move (2)
  - all others → ALU (1)

  ALU codes are 0 add, 1 sub, 2 shl, 3 shr, 4 cmp, 5 fdiv (0x0A), 6 fmul (0x0B), 7 fadd (0x0C), 8 fsub (0x0D), 9 fsin (0x0E), 10 fcos (0x0F), 11 dec (0x10), 12 inc (0x11). The ALU code is 0 for non-ALU actions.
- R7: In format 1, the destination depends on the opcode:
  - It is mode 2 with the bits 7:0 value for opcodes 0, 1, 4, 0x0A–0x0D, 9 and 0x12.
  - It is mode 2 with the bits 15:8 value for opcodes 2, 3, 0x0E, 0x0F, 0x10 and 0x11.
  - It is mode 0 for halt, push and pop.
- R8: Format-1 opcode 8 (store) gives source 2 mode 5 (register indirect) and destination mode 5 with the bits 7:0 value. Opcode 9 (load) gives source 1 mode 5. Opcodes above 0x12 are illegal.
- R9: In format 2, the opcode is bits 28:24 and the action is move. Source 1 is immediate with bits 15:0. Opcode 0 gives destination mode 3 (low half) and opcode 1 gives mode 4 (high half), both with the value in bits 23:16. Other opcodes are illegal.
- R10: While `exec_busy` is 1, `dec_ready` is 0 and every output register keeps its value whatever the input.
- R11: With `exec_busy`=0 and `in_valid`=0, the next edge gives `uop_valid`=0.
- R12: `err` stays 1 until reset, and legal words decode normally after it is set.
- R13: `uop_addr` carries the fetch address of the word that produced the micro-operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction word present |
| in_word | input | 32 | Instruction word |
| in_addr | input | ADDR_W | Fetch address of the word |
| exec_busy | input | 1 | Execute cannot accept a new micro-operation |
| dec_ready | output | 1 | Decode took the word this cycle |
| fetch_hold | output | 1 | Control transfer issued; fetch must wait |
| err | output | 1 | Sticky illegal-instruction flag |
| uop_valid | output | 1 | Micro-operation valid |
| uop_addr | output | ADDR_W | Address of the decoded word |
| uop_action | output | 4 | Action code |
| uop_alu | output | 4 | ALU operation code |
| uop_cond | output | 3 | Branch condition code |
| src1_mode | output | 3 | Source 1 mode |
| src1_val | output | 24 | Source 1 value |
| src2_mode | output | 3 | Source 2 mode |
| src2_val | output | 24 | Source 2 value |
| dst_mode | output | 3 | Destination mode |
| dst_val | output | 24 | Destination value |

## Verification
The bench walks every opcode of all three formats. It compares the full micro-operation, so a destination picked from the wrong operand field or a missed memory-mode swap shows as a field mismatch. Directed tests cover the following corners, and the failure each one catches:

- **Illegal encodings.** An illegal format, a gap in the format-0 opcode space, format-1 opcodes past 0x12 and format-2 opcodes past 1 are each tested. A design that let these through would present a valid micro-operation, or would leave `err` low.
- **Stall with a different word.** A stall is held while a different word sits on the input. A design that does not freeze would replace the held jump.
- **Sticky error.** The error flag is checked across later legal words.
- **Fetch hold.** The hold flag is checked on non-control words, where a loose decode would stop fetch needlessly.

// File: rtl/instr_decoder.sv
module instr_decoder #(
  parameter int ADDR_W = 32,
  parameter int VAL_W  = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [31:0]       in_word,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic              exec_busy,
  output logic              dec_ready,
  output logic              fetch_hold,
  output logic              err,
  output logic              uop_valid,
  output logic [ADDR_W-1:0] uop_addr,
  output logic [3:0]        uop_action,
  output logic [3:0]        uop_alu,
  output logic [2:0]        uop_cond,
  output logic [2:0]        src1_mode,
  output logic [VAL_W-1:0]  src1_val,
  output logic [2:0]        src2_mode,
  output logic [VAL_W-1:0]  src2_val,
  output logic [2:0]        dst_mode,
  output logic [VAL_W-1:0]  dst_val
);
  localparam logic [3:0] A_NOP = 4'd0, A_ALU = 4'd1, A_MOV = 4'd2, A_JMP = 4'd3,
                         A_CAL = 4'd4, A_RET = 4'd5, A_HLT = 4'd6, A_PSH = 4'd7,
                         A_POP = 4'd8;
  localparam logic [2:0] M_NONE = 3'd0, M_IMM = 3'd1, M_REG = 3'd2,
                         M_LO = 3'd3, M_HI = 3'd4, M_IND = 3'd5;
  localparam int PADR = VAL_W - 8;
  localparam int PADH = VAL_W - 16;

  logic [2:0]       fmt;
  logic [4:0]       op5;
  logic [12:0]      op13;
  logic [VAL_W-1:0] f1v, f2v;

  assign fmt  = in_word[31:29];
  assign op5  = in_word[28:24];
  assign op13 = in_word[28:16];
  assign f1v  = {{PADR{1'b0}}, in_word[15:8]};
  assign f2v  = {{PADR{1'b0}}, in_word[7:0]};
  assign dec_ready = !exec_busy;

  logic             legal;
  logic [3:0]       n_act, n_alu;
  logic [2:0]       n_cnd, n_m1, n_m2, n_md;
  logic [VAL_W-1:0] n_v1, n_v2, n_vd;

  always_comb begin
    legal = 1'b0;
    n_act = A_NOP; n_alu = 4'd0; n_cnd = 3'd0;
    n_m1 = M_NONE; n_v1 = '0;
    n_m2 = M_NONE; n_v2 = '0;
    n_md = M_NONE; n_vd = '0;
    case (fmt)
      3'd0: begin
        if (op5 == 5'h00) begin
          legal = 1'b1;
        end else if (op5[3] == 1'b0 && op5[2:0] != 3'd0 && op5[4:3] != 2'b11) begin
          legal = 1'b1;
          n_act = op5[4] ? A_CAL : A_JMP;
          n_cnd = op5[2:0] - 3'd1;
          n_md  = M_IMM;
          n_vd  = in_word[VAL_W-1:0];
        end else if (op5 == 5'h0F) begin
          legal = 1'b1;
          n_act = A_MOV;
          n_m1  = M_IMM;
          n_v1  = in_word[VAL_W-1:0];
          n_md  = M_REG;
          n_vd  = {{PADR{1'b0}}, 8'hFF};
        end else if (op5 == 5'h10) begin
          legal = 1'b1;
          n_act = A_RET;
        end
      end
      3'd1: begin
        if (op13 <= 13'h12) begin
          legal = 1'b1;
          n_m1 = (op13 == 13'h09) ? M_IND : M_REG;
          n_m2 = (op13 == 13'h08) ? M_IND : M_REG;
          n_v1 = f1v;
          n_v2 = f2v;
          case (op13[4:0])
            5'h05: n_act = A_HLT;
            5'h06: n_act = A_PSH;
            5'h07: n_act = A_POP;
            5'h08, 5'h09, 5'h12: n_act = A_MOV;
            default: n_act = A_ALU;
          endcase
          case (op13[4:0])
            5'h00: n_alu = 4'd0;
            5'h01: n_alu = 4'd1;
            5'h02: n_alu = 4'd2;
            5'h03: n_alu = 4'd3;
            5'h04: n_alu = 4'd4;
            5'h0A: n_alu = 4'd5;
            5'h0B: n_alu = 4'd6;
            5'h0C: n_alu = 4'd7;
            5'h0D: n_alu = 4'd8;
            5'h0E: n_alu = 4'd9;
            5'h0F: n_alu = 4'd10;
            5'h10: n_alu = 4'd11;
            5'h11: n_alu = 4'd12;
            default: n_alu = 4'd0;
          endcase
          case (op13[4:0])
            5'h02, 5'h03, 5'h0E, 5'h0F, 5'h10, 5'h11: begin
              n_md = M_REG; n_vd = f1v;
            end
            5'h05, 5'h06, 5'h07: begin
              n_md = M_NONE; n_vd = '0;
            end
            5'h08: begin
              n_md = M_IND; n_vd = f2v;
            end
            default: begin
              n_md = M_REG; n_vd = f2v;
            end
          endcase
        end
      end
      3'd2: begin
        if (op5 <= 5'h01) begin
          legal = 1'b1;
          n_act = A_MOV;
          n_m1  = M_IMM;
          n_v1  = {{PADH{1'b0}}, in_word[15:0]};
          n_md  = op5[0] ? M_HI : M_LO;
          n_vd  = {{PADR{1'b0}}, in_word[23:16]};
        end
      end
      default: legal = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      uop_valid  <= 1'b0;
      fetch_hold <= 1'b0;
      err        <= 1'b0;
      uop_addr   <= '0;
      uop_action <= A_NOP;
      uop_alu    <= '0;
      uop_cond   <= '0;
      src1_mode  <= M_NONE;
      src1_val   <= '0;
      src2_mode  <= M_NONE;
      src2_val   <= '0;
      dst_mode   <= M_NONE;
      dst_val    <= '0;
    end else if (!exec_busy) begin
      uop_valid  <= in_valid && legal;
      fetch_hold <= in_valid && legal &&
                    (n_act == A_JMP || n_act == A_CAL || n_act == A_RET);
      if (in_valid && !legal) err <= 1'b1;
      if (in_valid && legal) begin
        uop_addr   <= in_addr;
        uop_action <= n_act;
        uop_alu    <= n_alu;
        uop_cond   <= n_cnd;
        src1_mode  <= n_m1;
        src1_val   <= n_v1;
        src2_mode  <= n_m2;
        src2_val   <= n_v2;
        dst_mode   <= n_md;
        dst_val    <= n_vd;
      end
    end
  end
endmodule

// File: rtl/instr_decoder_chk.sv
module instr_decoder_chk #(
  parameter int ADDR_W = 32,
  parameter int VAL_W  = 24
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic [31:0]       in_word,
  input logic              exec_busy,
  input logic              fetch_hold,
  input logic              err,
  input logic              uop_valid,
  input logic [ADDR_W-1:0] uop_addr,
  input logic [3:0]        uop_action,
  input logic [VAL_W-1:0]  dst_val
);
  // R10
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    exec_busy |=> ($stable(uop_valid) && $stable(uop_action) &&
                   $stable(dst_val) && $stable(uop_addr) && $stable(fetch_hold)));

  // R12
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> err);

  // R2
  bad_format_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!exec_busy && in_valid && in_word[31:29] >= 3'd3) |=> (!uop_valid && err));

  // R5
  hold_ctrl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_hold |-> (uop_valid &&
                    (uop_action == 4'd3 || uop_action == 4'd4 || uop_action == 4'd5)));

  // R11
  idle_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!exec_busy && !in_valid) |=> !uop_valid);
endmodule

bind instr_decoder instr_decoder_chk #(.ADDR_W(ADDR_W), .VAL_W(VAL_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_word(in_word),
  .exec_busy(exec_busy), .fetch_hold(fetch_hold), .err(err),
  .uop_valid(uop_valid), .uop_addr(uop_addr), .uop_action(uop_action),
  .dst_val(dst_val)
);

// File: tb/instr_decoder_tb.sv
module instr_decoder_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 28;

  typedef struct packed {
    logic [31:0] w;
    logic [3:0]  act;
    logic [3:0]  alu;
    logic [2:0]  cnd;
    logic [2:0]  m1;
    logic [23:0] v1;
    logic [2:0]  m2;
    logic [23:0] v2;
    logic [2:0]  md;
    logic [23:0] vd;
    logic        hold;
  } vec_t;

  localparam vec_t VEC [NV] = '{
    '{32'h00000000, 4'd0, 4'd0,  3'd0, 3'd0, 24'h0,      3'd0, 24'h0,  3'd0, 24'h0,      1'b0},
    '{32'h01123456, 4'd3, 4'd0,  3'd0, 3'd0, 24'h0,      3'd0, 24'h0,  3'd1, 24'h123456, 1'b1},
    '{32'h07ABCDEF, 4'd3, 4'd0,  3'd6, 3'd0, 24'h0,      3'd0, 24'h0,  3'd1, 24'hABCDEF, 1'b1},
    '{32'h12000040, 4'd4, 4'd0,  3'd1, 3'd0, 24'h0,      3'd0, 24'h0,  3'd1, 24'h000040, 1'b1},
    '{32'h15000100, 4'd4, 4'd0,  3'd4, 3'd0, 24'h0,      3'd0, 24'h0,  3'd1, 24'h000100, 1'b1},
    '{32'h10000000, 4'd5, 4'd0,  3'd0, 3'd0, 24'h0,      3'd0, 24'h0,  3'd0, 24'h0,      1'b1},
    '{32'h0F00FFF0, 4'd2, 4'd0,  3'd0, 3'd1, 24'h00FFF0, 3'd0, 24'h0,  3'd2, 24'hFF,     1'b0},
    '{32'h20000302, 4'd1, 4'd0,  3'd0, 3'd2, 24'h3,      3'd2, 24'h2,  3'd2, 24'h2,      1'b0},
    '{32'h20010504, 4'd1, 4'd1,  3'd0, 3'd2, 24'h5,      3'd2, 24'h4,  3'd2, 24'h4,      1'b0},
    '{32'h20020706, 4'd1, 4'd2,  3'd0, 3'd2, 24'h7,      3'd2, 24'h6,  3'd2, 24'h7,      1'b0},
    '{32'h20030A0B, 4'd1, 4'd3,  3'd0, 3'd2, 24'hA,      3'd2, 24'hB,  3'd2, 24'hA,      1'b0},
    '{32'h20040102, 4'd1, 4'd4,  3'd0, 3'd2, 24'h1,      3'd2, 24'h2,  3'd2, 24'h2,      1'b0},
    '{32'h200A0102, 4'd1, 4'd5,  3'd0, 3'd2, 24'h1,      3'd2, 24'h2,  3'd2, 24'h2,      1'b0},
    '{32'h200B0304, 4'd1, 4'd6,  3'd0, 3'd2, 24'h3,      3'd2, 24'h4,  3'd2, 24'h4,      1'b0},
    '{32'h200C0506, 4'd1, 4'd7,  3'd0, 3'd2, 24'h5,      3'd2, 24'h6,  3'd2, 24'h6,      1'b0},
    '{32'h200D0708, 4'd1, 4'd8,  3'd0, 3'd2, 24'h7,      3'd2, 24'h8,  3'd2, 24'h8,      1'b0},
    '{32'h200E0100, 4'd1, 4'd9,  3'd0, 3'd2, 24'h1,      3'd2, 24'h0,  3'd2, 24'h1,      1'b0},
    '{32'h200F0809, 4'd1, 4'd10, 3'd0, 3'd2, 24'h8,      3'd2, 24'h9,  3'd2, 24'h8,      1'b0},
    '{32'h20100C0D, 4'd1, 4'd11, 3'd0, 3'd2, 24'hC,      3'd2, 24'hD,  3'd2, 24'hC,      1'b0},
    '{32'h20110A0B, 4'd1, 4'd12, 3'd0, 3'd2, 24'hA,      3'd2, 24'hB,  3'd2, 24'hA,      1'b0},
    '{32'h20080102, 4'd2, 4'd0,  3'd0, 3'd2, 24'h1,      3'd5, 24'h2,  3'd5, 24'h2,      1'b0},
    '{32'h20090304, 4'd2, 4'd0,  3'd0, 3'd5, 24'h3,      3'd2, 24'h4,  3'd2, 24'h4,      1'b0},
    '{32'h20120506, 4'd2, 4'd0,  3'd0, 3'd2, 24'h5,      3'd2, 24'h6,  3'd2, 24'h6,      1'b0},
    '{32'h20050000, 4'd6, 4'd0,  3'd0, 3'd2, 24'h0,      3'd2, 24'h0,  3'd0, 24'h0,      1'b0},
    '{32'h20060900, 4'd7, 4'd0,  3'd0, 3'd2, 24'h9,      3'd2, 24'h0,  3'd0, 24'h0,      1'b0},
    '{32'h20070A00, 4'd8, 4'd0,  3'd0, 3'd2, 24'hA,      3'd2, 24'h0,  3'd0, 24'h0,      1'b0},
    '{32'h4003BEEF, 4'd2, 4'd0,  3'd0, 3'd1, 24'hBEEF,   3'd0, 24'h0,  3'd3, 24'h3,      1'b0},
    '{32'h410FCAFE, 4'd2, 4'd0,  3'd0, 3'd1, 24'hCAFE,   3'd0, 24'h0,  3'd4, 24'hF,      1'b0}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [31:0] in_word = '0;
  logic [31:0] in_addr = '0;
  logic        exec_busy = 1'b0;
  logic        dec_ready, fetch_hold, err, uop_valid;
  logic [31:0] uop_addr;
  logic [3:0]  uop_action, uop_alu;
  logic [2:0]  uop_cond, src1_mode, src2_mode, dst_mode;
  logic [23:0] src1_val, src2_val, dst_val;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  instr_decoder dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_word(in_word),
    .in_addr(in_addr), .exec_busy(exec_busy), .dec_ready(dec_ready),
    .fetch_hold(fetch_hold), .err(err), .uop_valid(uop_valid),
    .uop_addr(uop_addr), .uop_action(uop_action), .uop_alu(uop_alu),
    .uop_cond(uop_cond), .src1_mode(src1_mode), .src1_val(src1_val),
    .src2_mode(src2_mode), .src2_val(src2_val), .dst_mode(dst_mode),
    .dst_val(dst_val)
  );

  function automatic logic [92:0] bundle();
    return {uop_action, uop_alu, uop_cond, src1_mode, src1_val,
            src2_mode, src2_val, dst_mode, dst_val, fetch_hold};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [127:0] got,
                     input logic [127:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s got=%0h exp=%0h", req, got, exp);
    end
  endtask

  task automatic step(input bit v, input logic [31:0] w, input bit busy,
                      input logic [31:0] a);
    @(negedge clk);
    in_valid = v; in_word = w; exec_busy = busy; in_addr = a;
    @(posedge clk);
    #1;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; in_valid = 1'b0; exec_busy = 1'b0;
    @(posedge clk);
    #1;
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    logic [92:0] held;
    do_reset();
    #1;
    // R1 reset state
    chk(uop_valid == 0 && fetch_hold == 0 && err == 0 && bundle() == '0 &&
        uop_addr == 0, "R1 reset",
        {uop_valid, fetch_hold, err, bundle()[31:0]}, 0);

    // R3 R4 R5 R6 R7 R8 R9 R13 table walk
    for (int i = 0; i < NV; i++) begin
      step(1'b1, VEC[i].w, 1'b0, 32'h1000 + 32'(i * 4));
      chk(uop_valid && !err && bundle() == {VEC[i].act, VEC[i].alu, VEC[i].cnd,
          VEC[i].m1, VEC[i].v1, VEC[i].m2, VEC[i].v2, VEC[i].md, VEC[i].vd, VEC[i].hold},
          "R3/R4/R5/R6/R7/R8/R9 vector", bundle(),
          {VEC[i].act, VEC[i].alu, VEC[i].cnd, VEC[i].m1, VEC[i].v1,
           VEC[i].m2, VEC[i].v2, VEC[i].md, VEC[i].vd, VEC[i].hold});
      // R13 address carried
      chk(uop_addr == 32'h1000 + 32'(i * 4), "R13 addr", uop_addr,
          32'h1000 + 32'(i * 4));
    end

    // R11 idle input
    step(1'b0, 32'h01000010, 1'b0, 32'h0);
    chk(uop_valid == 0 && fetch_hold == 0, "R11 idle", {uop_valid, fetch_hold}, 0);

    // R10 stall holds a jump while a different word is offered
    step(1'b1, 32'h03000ABC, 1'b0, 32'h2000);
    held = bundle();
    @(negedge clk);
    in_valid = 1'b1; in_word = 32'h20000302; exec_busy = 1'b1; in_addr = 32'h3000;
    #1;
    chk(dec_ready == 0, "R10 ready low", dec_ready, 0);
    @(posedge clk); #1;
    @(posedge clk); #1;
    chk(uop_valid && bundle() == held && uop_addr == 32'h2000, "R10 hold",
        bundle(), held);
    step(1'b1, 32'h20000302, 1'b0, 32'h3000);
    chk(dec_ready == 1 && uop_valid && uop_action == 4'd1 && fetch_hold == 0,
        "R10 resume", {dec_ready, uop_action, fetch_hold}, {1'b1, 4'd1, 1'b0});

    // R2 illegal format, R12 sticky
    step(1'b1, 32'h60000000, 1'b0, 32'h0);
    chk(uop_valid == 0 && err == 1, "R2 bad fmt", {uop_valid, err}, 2'b01);
    step(1'b1, 32'h20110A0B, 1'b0, 32'h0);
    chk(err == 1 && uop_valid == 1 && uop_alu == 4'd12, "R12 sticky",
        {err, uop_valid, uop_alu}, {1'b1, 1'b1, 4'd12});
    step(1'b0, 32'h0, 1'b0, 32'h0);
    chk(err == 1, "R12 sticky idle", err, 1);
    do_reset(); #1;
    chk(err == 0, "R12 reset clears", err, 0);

    // R4 gap in format 0
    step(1'b1, 32'h08000000, 1'b0, 32'h0);
    chk(uop_valid == 0 && err == 1 && fetch_hold == 0, "R4 f0 illegal",
        {uop_valid, err}, 2'b01);
    do_reset();
    step(1'b1, 32'h18000000, 1'b0, 32'h0);
    chk(uop_valid == 0 && err == 1, "R4 f0 0x18 illegal", {uop_valid, err}, 2'b01);
    do_reset();
    // R8 format-1 opcode past 0x12
    step(1'b1, 32'h20130102, 1'b0, 32'h0);
    chk(uop_valid == 0 && err == 1, "R8 f1 illegal", {uop_valid, err}, 2'b01);
    do_reset();
    // R9 format-2 opcode 2
    step(1'b1, 32'h42011234, 1'b0, 32'h0);
    chk(uop_valid == 0 && err == 1, "R9 f2 illegal", {uop_valid, err}, 2'b01);
    do_reset();
    // R2 format 7
    step(1'b1, 32'hE0000000, 1'b0, 32'h0);
    chk(uop_valid == 0 && err == 1, "R2 fmt7", {uop_valid, err}, 2'b01);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog got=hung exp=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule